// File: doc/BRIEF.md
# Frequency Sweep and Lock Supervisor

This block supervises frequency acquisition for a clock-recovery loop. It watches the quantized value of the loop's frequency integrator together with a phase-lock flag and a carrier-detect flag. While the loop has never locked, or has been out of phase lock for longer than a configurable hold-off, it drives a signed sweep increment into the integrator's summing point. That increment pushes the loop frequency up or down. Its direction reverses whenever the integrator enters the band next to the rail it is heading for. The sweep is removed in the same cycle that phase lock is seen.

The same rail bands serve as the no-data detector. An integrator with no data to track drifts into one rail and stays there. When the integrator stays inside one band for a long consecutive run, the block declares that data is absent. The data-present output combines this saturation verdict with the carrier-detect input. The overall lock output is data-present ANDed with phase lock. The step magnitude and the hold-off length are plain configuration pins, sampled every cycle. Every pin is a plain control or status signal: the block has no streaming data path, so no port uses a valid/ready handshake and no back-pressure rules apply.

Top module: `sweep_lock_ctrl`

## Requirements
- R1: Reset behaviour. The block uses an active-low asynchronous reset. After reset the sweep direction is up and no lock has yet been seen. Both saturation verdicts are clear. With phase lock low, `sweep_inc` therefore equals +`cfg_step` in the first cycle after reset.
- R2: Sweep value while active. While the sweep is active, `sweep_inc` is +`cfg_step` when the direction is up and -`cfg_step` when it is down. A `cfg_step` of 0 gives an increment of 0.
- R3: Immediate stop on lock. In any cycle in which `phase_lock` is high, `sweep_inc` is 0 in that same cycle.
- R4: Rail bands. With `M` = 2^(INT_W-1)-1 (32767 at the default width), the high band is `integ_val` >= `M` - `M`/100 (32440). The low band is `integ_val` <= -`M`-1 + `M`/100 (-32441).
- R5: Direction reversal. At a clock edge where `integ_val` lies in the band of the rail the direction points toward, the direction reverses. The new direction shows from the next cycle. A sample in the opposite band does not change the direction.
- R6: No-data detection. Once `integ_val` has been sampled inside one band on `SAT_CYCLES` (256) consecutive edges, that band's saturation verdict is set from the next cycle. The verdict clears after the first edge at which the value is sampled outside that band.
- R7: Data present. `data_present` is high exactly when `carrier_det` is high and neither saturation verdict is set.
- R8: Overall lock. `lock_out` is `data_present` AND `phase_lock`.
- R9: Hold-off after loss of lock. Once phase lock has been sampled high, the sweep stays off while phase lock is low. It resumes, in its last direction, in the cycle after the edge that completes `cfg_holdoff`+1 consecutive low samples. Any high sample restarts this count.
- R10: First acquisition. Before phase lock has ever been sampled high since reset, the sweep is active in every cycle in which `phase_lock` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| integ_val | input | INT_W (16) | Signed quantized frequency-integrator value |
| phase_lock | input | 1 | Phase-lock flag from the phase-lock detector |
| carrier_det | input | 1 | Carrier-detect flag, high when carrier is present |
| cfg_step | input | STEP_W (8) | Unsigned sweep step magnitude |
| cfg_holdoff | input | HOLD_W (8) | Hold-off length, in cycles, before the sweep resumes |
| sweep_inc | output | STEP_W+1 (9) | Signed sweep increment for the integrator summing point |
| data_present | output | 1 | High when data is judged present |
| lock_out | output | 1 | Overall lock indication |

## Verification
Two situations are hard to reach from the ports. The first is the no-data verdict, which needs the integrator held inside a rail band for hundreds of unbroken cycles. The second is the boundary one cycle short of that run. The stimulus holds the value for exactly 255 cycles and then leaves the band, which must not trip the verdict. It then parks the value in each band for well over 256 cycles and returns it to mid-range, which must clear the verdict. The band edges are exercised by single samples one count inside and one count outside each threshold. The hold-off is probed with low runs of exactly `cfg_holdoff` cycles and of one cycle more, so both sides of the resume point are visited.

// File: rtl/sweep_lock_pkg.sv
package sweep_lock_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } sweep_dir_e;

  // Rail index used by the generate loop over the two band monitors
  localparam int RAIL_LO = 0;
  localparam int RAIL_HI = 1;
  localparam int NUM_RAILS = 2;

endpackage

// File: rtl/rail_monitor.sv
module rail_monitor #(
  parameter int INT_W      = 16,
  parameter int SAT_CYCLES = 256,
  parameter int IS_HIGH    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [INT_W-1:0] value,
  output logic                    in_band,
  output logic                    saturated
);
  localparam int MAXV   = (1 << (INT_W-1)) - 1;
  localparam int MARGIN = MAXV / 100;
  localparam int HI_T   = MAXV - MARGIN;
  localparam int LO_T   = -MAXV - 1 + MARGIN;
  localparam int CNT_W  = $clog2(SAT_CYCLES + 1);
  localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(SAT_CYCLES);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(SAT_CYCLES - 1);

  logic [CNT_W-1:0] run_q;

  generate
    if (IS_HIGH != 0) begin : g_hi
      assign in_band = (int'(value) >= HI_T);
    end else begin : g_lo
      assign in_band = (int'(value) <= LO_T);
    end
  endgenerate

  // Consecutive-sample run; saturated once the run reaches SAT_CYCLES
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      saturated <= 1'b0;
    end else if (!in_band) begin
      run_q     <= '0;
      saturated <= 1'b0;
    end else begin
      if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
      if (run_q >= RUN_LAST) saturated <= 1'b1;
    end
  end
endmodule

// File: rtl/sweep_engine.sv
module sweep_engine
  import sweep_lock_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int HOLD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    phase_lock,
  input  logic                    band_hi,
  input  logic                    band_lo,
  input  logic [STEP_W-1:0]       cfg_step,
  input  logic [HOLD_W-1:0]       cfg_holdoff,
  output logic signed [STEP_W:0]  sweep_inc
);
  sweep_dir_e        dir_q;
  logic              parked_q;
  logic [HOLD_W-1:0] low_run_q;
  logic              active;
  logic signed [STEP_W:0] mag;

  // Direction follows the rail it is heading for
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP && band_hi) begin
      dir_q <= DIR_DOWN;
    end else if (dir_q == DIR_DOWN && band_lo) begin
      dir_q <= DIR_UP;
    end
  end

  // Parked after a lock; released after cfg_holdoff+1 low samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked_q  <= 1'b0;
      low_run_q <= '0;
    end else if (phase_lock) begin
      parked_q  <= 1'b1;
      low_run_q <= '0;
    end else if (parked_q) begin
      if (low_run_q >= cfg_holdoff) begin
        parked_q  <= 1'b0;
        low_run_q <= '0;
      end else begin
        low_run_q <= low_run_q + 1'b1;
      end
    end
  end

  always_comb begin
    active = !parked_q && !phase_lock;
    mag    = $signed({1'b0, cfg_step});
    if (!active)              sweep_inc = '0;
    else if (dir_q == DIR_UP) sweep_inc = mag;
    else                      sweep_inc = -mag;
  end
endmodule

// File: rtl/lock_report.sv
module lock_report (
  input  logic sat_hi,
  input  logic sat_lo,
  input  logic carrier_det,
  input  logic phase_lock,
  output logic data_present,
  output logic lock_out
);
  always_comb begin
    data_present = carrier_det && !(sat_hi || sat_lo);
    lock_out     = data_present && phase_lock;
  end
endmodule

// File: rtl/sweep_lock_ctrl.sv
module sweep_lock_ctrl
  import sweep_lock_pkg::*;
#(
  parameter int INT_W      = 16,
  parameter int STEP_W     = 8,
  parameter int HOLD_W     = 8,
  parameter int SAT_CYCLES = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [INT_W-1:0] integ_val,
  input  logic                    phase_lock,
  input  logic                    carrier_det,
  input  logic [STEP_W-1:0]       cfg_step,
  input  logic [HOLD_W-1:0]       cfg_holdoff,
  output logic signed [STEP_W:0]  sweep_inc,
  output logic                    data_present,
  output logic                    lock_out
);
  logic [NUM_RAILS-1:0] band;
  logic [NUM_RAILS-1:0] sat;

  generate
    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
      rail_monitor #(
        .INT_W     (INT_W),
        .SAT_CYCLES(SAT_CYCLES),
        .IS_HIGH   ((g == RAIL_HI) ? 1 : 0)
      ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .value    (integ_val),
        .in_band  (band[g]),
        .saturated(sat[g])
      );
    end
  endgenerate

  sweep_engine #(
    .STEP_W(STEP_W),
    .HOLD_W(HOLD_W)
  ) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_lock (phase_lock),
    .band_hi    (band[RAIL_HI]),
    .band_lo    (band[RAIL_LO]),
    .cfg_step   (cfg_step),
    .cfg_holdoff(cfg_holdoff),
    .sweep_inc  (sweep_inc)
  );

  lock_report u_report (
    .sat_hi      (sat[RAIL_HI]),
    .sat_lo      (sat[RAIL_LO]),
    .carrier_det (carrier_det),
    .phase_lock  (phase_lock),
    .data_present(data_present),
    .lock_out    (lock_out)
  );
endmodule

// File: rtl/sweep_lock_ctrl_chk.sv
module sweep_lock_ctrl_chk #(
  parameter int INT_W  = 16,
  parameter int STEP_W = 8,
  parameter int HOLD_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic signed [INT_W-1:0] integ_val,
  input logic                    phase_lock,
  input logic                    carrier_det,
  input logic [STEP_W-1:0]       cfg_step,
  input logic [HOLD_W-1:0]       cfg_holdoff,
  input logic signed [STEP_W:0]  sweep_inc,
  input logic                    data_present,
  input logic                    lock_out
);
  localparam int MAXV   = (1 << (INT_W-1)) - 1;
  localparam int MARGIN = MAXV / 100;

  logic hi_b, lo_b;
  logic signed [STEP_W:0] pos_s, neg_s;
  assign hi_b  = int'(integ_val) >= (MAXV - MARGIN);
  assign lo_b  = int'(integ_val) <= (-MAXV - 1 + MARGIN);
  assign pos_s = $signed({1'b0, cfg_step});
  assign neg_s = -pos_s;

  p_locked_no_sweep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_lock |-> (sweep_inc == '0));

  p_step_magnitude_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_inc != '0) |-> (sweep_inc == pos_s || sweep_inc == neg_s));

  p_turn_at_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_inc > 0 && hi_b) |=> (sweep_inc <= 0));

  p_turn_at_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_inc < 0 && lo_b) |=> (sweep_inc >= 0));

  p_out_of_band_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_b && !lo_b) |=> (data_present == carrier_det));

  p_no_carrier_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_det |-> !data_present);

  p_lock_needs_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_out |-> (phase_lock && data_present));

  p_parked_after_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_lock |=> (sweep_inc == '0));
endmodule

bind sweep_lock_ctrl sweep_lock_ctrl_chk #(
  .INT_W (INT_W),
  .STEP_W(STEP_W),
  .HOLD_W(HOLD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .integ_val   (integ_val),
  .phase_lock  (phase_lock),
  .carrier_det (carrier_det),
  .cfg_step    (cfg_step),
  .cfg_holdoff (cfg_holdoff),
  .sweep_inc   (sweep_inc),
  .data_present(data_present),
  .lock_out    (lock_out)
);

// File: tb/sweep_lock_ctrl_tb_top.sv
module sweep_lock_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INT_W  = 16;
  localparam int STEP_W = 8;
  localparam int HOLD_W = 8;
  localparam int SATN   = 256;
  localparam int MAXV   = (1 << (INT_W-1)) - 1;
  localparam int HI_T   = MAXV - MAXV / 100;
  localparam int LO_T   = -MAXV - 1 + MAXV / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [INT_W-1:0] integ_val = '0;
  logic phase_lock = 1'b0;
  logic carrier_det = 1'b1;
  logic [STEP_W-1:0] cfg_step = 8'd16;
  logic [HOLD_W-1:0] cfg_holdoff = 8'd5;
  logic signed [STEP_W:0] sweep_inc;
  logic data_present, lock_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  int  m_hi_run, m_lo_run, m_low_run;
  bit  m_sat_hi, m_sat_lo, m_up, m_parked;

  always #(CLK_PERIOD/2) clk = ~clk;

  sweep_lock_ctrl #(.INT_W(INT_W), .STEP_W(STEP_W), .HOLD_W(HOLD_W), .SAT_CYCLES(SATN)) dut_i (
    .clk(clk), .rst_n(rst_n), .integ_val(integ_val), .phase_lock(phase_lock),
    .carrier_det(carrier_det), .cfg_step(cfg_step), .cfg_holdoff(cfg_holdoff),
    .sweep_inc(sweep_inc), .data_present(data_present), .lock_out(lock_out));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi_run = 0; m_lo_run = 0; m_low_run = 0;
      m_sat_hi = 0; m_sat_lo = 0; m_up = 1; m_parked = 0;
    end else begin
      bit hb, lb;
      hb = int'(integ_val) >= HI_T;
      lb = int'(integ_val) <= LO_T;
      m_hi_run = hb ? ((m_hi_run < SATN) ? m_hi_run + 1 : SATN) : 0;
      m_lo_run = lb ? ((m_lo_run < SATN) ? m_lo_run + 1 : SATN) : 0;
      m_sat_hi = (m_hi_run >= SATN);
      m_sat_lo = (m_lo_run >= SATN);
      if (m_up && hb) m_up = 0;
      else if (!m_up && lb) m_up = 1;
      if (phase_lock) begin
        m_parked = 1; m_low_run = 0;
      end else if (m_parked) begin
        m_low_run++;
        if (m_low_run > int'(cfg_holdoff)) begin
          m_parked = 0; m_low_run = 0;
        end
      end
    end
  end

  task automatic check_one(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int e_sw;
    bit e_dp;
    e_dp = carrier_det && !m_sat_hi && !m_sat_lo;
    if (m_parked || phase_lock) e_sw = 0;
    else e_sw = m_up ? int'(cfg_step) : -int'(cfg_step);
    check_one("sweep_inc", int'(sweep_inc), e_sw);
    check_one("data_present", int'(data_present), int'(e_dp));
    check_one("lock_out", int'(lock_out), int'(e_dp && phase_lock));
  endtask

  task automatic step(int v, bit pl, bit cd, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      integ_val = INT_W'(v); phase_lock = pl; carrier_det = cd;
      #1 compare();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    tag = "R1";   // reset state: sweep up, data present, no lock
    check_one("sweep_inc", int'(sweep_inc), 16);
    check_one("data_present", int'(data_present), 1);
    check_one("lock_out", int'(lock_out), 0);
    tag = "R10";  step(1000, 0, 1, 5);
    tag = "R4";   step(HI_T - 1, 0, 1, 2);   // just below high band: still up
    tag = "R5";   step(HI_T, 0, 1, 1);       // enters high band: flips
    step(0, 0, 1, 3);
    tag = "R4";   step(LO_T + 1, 0, 1, 2);   // just above low band
    tag = "R5";   step(HI_T, 0, 1, 1);       // opposite band while heading down: no flip
    step(0, 0, 1, 2);
    step(LO_T, 0, 1, 1);
    step(0, 0, 1, 3);
    tag = "R3";   step(0, 1, 1, 4);
    tag = "R8";   step(100, 1, 1, 2);
    tag = "R9";   step(0, 0, 1, 5);          // exactly holdoff lows: still parked
    step(0, 1, 1, 1);
    step(0, 0, 1, 9);                        // resumes after holdoff+1
    cfg_holdoff = 8'd0;
    step(0, 1, 1, 2);
    step(0, 0, 1, 3);
    cfg_holdoff = 8'd3;
    tag = "R7";   step(0, 0, 0, 4);
    step(0, 1, 0, 3);
    tag = "R6";   step(MAXV, 1, 1, SATN - 1); // one short: no verdict
    step(0, 1, 1, 3);
    step(32500, 1, 1, SATN + 20);
    step(0, 1, 1, 3);
    step(-MAXV - 1, 0, 1, SATN + 20);
    step(LO_T, 1, 1, 5);
    step(0, 1, 1, 3);
    tag = "R2";   cfg_step = 8'd0; step(0, 0, 1, 8);
    cfg_step = 8'd255; step(0, 0, 1, 4);
    step(HI_T, 0, 1, 1);
    step(0, 0, 1, 4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule